// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block generates the system reset for a supply supervisor. It watches a digital flag from an external comparator that reports the supply below its trip point, and it watches a manual-reset input. Either source asserts reset. Once the source clears, reset is held for a programmable minimum number of clock cycles. Each input first passes through a two-flop synchronizer and then a glitch filter that counts clock cycles. Each input has its own filter width, so short supply dips and short contact bounces are rejected separately.

In the shared-pin variant (`SHARED_PIN=1`), the manual input senses the same open-drain line that the block pulls. The block therefore ignores falling edges that arrive while it is driving the line itself. The manual input is edge-triggered. A qualified press of any length produces one full timeout, and a button held down does not hold reset beyond that timeout. A parameter selects the polarity of the reset level output. A separate status flag tells other logic whether reset is active.

The sequencer has three named states:
- `ST_HOLD`: the filtered supply flag is low-side, or power-on reset is applied.
- `ST_STRETCH`: the timeout counter is running.
- `ST_RUN`: reset is released.

The transitions are:
- HOLD→STRETCH when the supply is good.
- STRETCH→HOLD on a supply drop.
- STRETCH→STRETCH with the count cleared on a manual trigger (restart).
- STRETCH→RUN when the count reaches `TIMEOUT_CYC-1`.
- RUN→HOLD on a supply drop.
- RUN→STRETCH on a manual trigger.

`TIMEOUT_CYC` must exceed `MR_FILT_CYC+3`.

Top module: `supply_reset_ctl`

## Requirements
- R1: A supply-low flag held for at least `SUP_FILT_CYC` clock samples asserts `rst_active_o` within `SUP_FILT_CYC+4` cycles, and reset stays asserted for as long as the flag stays high.
- R2: When the supply flag falls, `rst_active_o` drops exactly `SUP_FILT_CYC+TIMEOUT_CYC+3` clock edges after the edge that first samples the flag low. The bench accepts ±1 edge.
- R3: A supply-low pulse lasting fewer than `SUP_FILT_CYC` clock samples does not assert reset.
- R4: A manual low pulse lasting fewer than `MR_FILT_CYC` samples does not assert reset.
- R5: A manual low pulse of at least `MR_FILT_CYC` samples, even one far shorter than the timeout, gives a reset that ends `MR_FILT_CYC+TIMEOUT_CYC+3` edges after the press begins (±1).
- R6: The manual input is edge-triggered. A press held well beyond the timeout still releases reset at the R5 time, and releasing the button afterwards does not start a new reset.
- R7: In the shared-pin variant, the falling level caused by the block's own drive is not taken as a manual press. After a timeout ends, reset stays released while no input changes.
- R8: A qualified manual press during a running timeout restarts the count. Reset then ends at the R5 time measured from the new press.
- R9: `rst_drive_o` is 1 while reset is active. `rst_level_o` is 0 when active for `ACTIVE_LOW=1` and 1 when active for `ACTIVE_LOW=0`, and it is the inverse when inactive.
- R10: `rst_active_o` is 1 during power-on reset (`rst_n`=0). It stays 1 until a timeout completes after `rst_n` rises, which takes `SUP_FILT_CYC+TIMEOUT_CYC+3` edges (±1) with the supply good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| vlow_i | input | 1 | Comparator flag, 1 = supply below trip point (asynchronous) |
| mr_sense_i | input | 1 | Sensed manual-reset line, falling edge = press (asynchronous) |
| rst_drive_o | output | 1 | Pull enable for the open-drain reset line, 1 = drive asserted level |
| rst_level_o | output | 1 | Reset level in the polarity chosen by `ACTIVE_LOW` |
| rst_active_o | output | 1 | Status flag, 1 while reset is active |

## Verification
The supply path is exercised with three inputs: a long dip, a dip one sample short of the filter width, and a dip just over it. Comparing them separates glitch rejection from assertion and confirms the exact release latency. The manual path is exercised with four inputs: a sub-filter pulse, a brief qualified press, a press held for three timeouts, and, on the active-high instance with a separate input, a second press in mid-timeout. Together these show the filtering, the stretch to a full timeout, edge triggering, and the restart. Watching the shared-pin instance after each release shows that its own drive never re-triggers it.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } rst_state_e;
endpackage

// File: rtl/rstc_sync2.sv
module rstc_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/rstc_glitch_filter.sv
// Output follows the input only after the input has differed from it
// for FILT_CYC consecutive samples; shorter excursions are dropped.
module rstc_glitch_filter #(
    parameter int   FILT_CYC = 4,
    parameter logic RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic          filt_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= RST_VAL;
            cnt_q  <= '0;
        end else if (raw_i == filt_q) begin
            cnt_q  <= '0;
        end else if (cnt_q == LAST) begin
            filt_q <= raw_i;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign filt_o = filt_q;
endmodule

// File: rtl/rstc_timeout_fsm.sv
module rstc_timeout_fsm
    import rstc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_low_i,
    input  logic mr_trig_i,
    output logic active_o
);
    localparam int CW = (TIMEOUT_CYC < 4) ? 2 : $clog2(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    rst_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!sup_low_i) begin
                    state_d = ST_STRETCH;
                    cnt_d   = '0;
                end
            end
            ST_STRETCH: begin
                if (sup_low_i) begin
                    state_d = ST_HOLD;
                end else if (mr_trig_i) begin
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (sup_low_i) begin
                    state_d = ST_HOLD;
                end else if (mr_trig_i) begin
                    state_d = ST_STRETCH;
                    cnt_d   = '0;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        active_o = (state_q != ST_RUN);
    end
endmodule

// File: rtl/supply_reset_ctl.sv
module supply_reset_ctl #(
    parameter bit ACTIVE_LOW   = 1'b1,
    parameter bit SHARED_PIN   = 1'b1,
    parameter int TIMEOUT_CYC  = 25_000_000,
    parameter int SUP_FILT_CYC = 4,
    parameter int MR_FILT_CYC  = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vlow_i,
    input  logic mr_sense_i,
    output logic rst_drive_o,
    output logic rst_level_o,
    output logic rst_active_o
);
    logic sup_sync;
    logic mr_sync;
    logic sup_low_f;
    logic mr_f;
    logic mr_f_q;
    logic mr_fell;
    logic mr_trig;
    logic active;

    rstc_sync2 #(.RST_VAL(1'b1)) u_sup_sync (
        .clk(clk), .rst_n(rst_n), .async_i(vlow_i), .sync_o(sup_sync)
    );
    rstc_sync2 #(.RST_VAL(1'b1)) u_mr_sync (
        .clk(clk), .rst_n(rst_n), .async_i(mr_sense_i), .sync_o(mr_sync)
    );

    rstc_glitch_filter #(.FILT_CYC(SUP_FILT_CYC), .RST_VAL(1'b1)) u_sup_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sup_sync), .filt_o(sup_low_f)
    );
    rstc_glitch_filter #(.FILT_CYC(MR_FILT_CYC), .RST_VAL(1'b1)) u_mr_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(mr_sync), .filt_o(mr_f)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mr_f_q <= 1'b1;
        else        mr_f_q <= mr_f;
    end

    assign mr_fell = mr_f_q & ~mr_f;

    generate
        if (SHARED_PIN) begin : g_mask
            // own pull on the line must not read back as a press
            assign mr_trig = mr_fell & ~active;
        end else begin : g_nomask
            assign mr_trig = mr_fell;
        end
    endgenerate

    rstc_timeout_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sup_low_i(sup_low_f),
        .mr_trig_i(mr_trig), .active_o(active)
    );

    assign rst_drive_o  = active;
    assign rst_active_o = active;

    generate
        if (ACTIVE_LOW) begin : g_lo
            assign rst_level_o = ~active;
        end else begin : g_hi
            assign rst_level_o = active;
        end
    endgenerate
endmodule

// File: rtl/supply_reset_ctl_chk.sv
module supply_reset_ctl_chk #(
    parameter int TIMEOUT_CYC = 25_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic rst_active_o,
    input logic sup_low_f,
    input logic mr_trig
);
    logic [31:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    run_len <= '0;
        else if (!rst_active_o)        run_len <= '0;
        else if (run_len != '1)        run_len <= run_len + 1'b1;
    end

    a_r1_low_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
        sup_low_f |=> rst_active_o);

    a_r2_min_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active_o) |-> (run_len >= 32'(TIMEOUT_CYC)));

    a_r5_trigger_starts_reset: assert property (@(posedge clk) disable iff (!rst_n)
        mr_trig |=> rst_active_o);

    a_r7_idle_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_active_o && !sup_low_f && !mr_trig) |=> !rst_active_o);
endmodule

bind supply_reset_ctl supply_reset_ctl_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_active_o(rst_active_o),
    .sup_low_f(sup_low_f), .mr_trig(mr_trig)
);

// File: tb/tb_supply_reset_ctl.sv
`timescale 1ns/1ps
module tb_supply_reset_ctl;
    localparam int T  = 120;
    localparam int SF = 4;
    localparam int MF = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vlow = 1'b0;
    logic btn_lo = 1'b0;
    logic btn_ah = 1'b0;
    logic drv_lo, lvl_lo, act_lo;
    logic drv_ah, lvl_ah, act_ah;
    logic pin_lo;
    logic mr_ah;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    assign pin_lo = !(drv_lo || btn_lo);
    assign mr_ah  = !btn_ah;

    supply_reset_ctl #(.ACTIVE_LOW(1'b1), .SHARED_PIN(1'b1), .TIMEOUT_CYC(T),
                       .SUP_FILT_CYC(SF), .MR_FILT_CYC(MF)) dut (
        .clk(clk), .rst_n(rst_n), .vlow_i(vlow), .mr_sense_i(pin_lo),
        .rst_drive_o(drv_lo), .rst_level_o(lvl_lo), .rst_active_o(act_lo)
    );

    supply_reset_ctl #(.ACTIVE_LOW(1'b0), .SHARED_PIN(1'b0), .TIMEOUT_CYC(T),
                       .SUP_FILT_CYC(SF), .MR_FILT_CYC(MF)) dut_ah (
        .clk(clk), .rst_n(rst_n), .vlow_i(vlow), .mr_sense_i(mr_ah),
        .rst_drive_o(drv_ah), .rst_level_o(lvl_ah), .rst_active_o(act_ah)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // sel: 0 vlow (watch dut), 1 btn_lo (watch dut), 2 btn_ah (watch dut_ah)
    task automatic pulse_and_watch(input int sel, input int len, input int limit,
                                   output int n_fall, output bit seen);
        logic a;
        n_fall = 0;
        seen   = 1'b0;
        @(negedge clk);
        case (sel)
            0: vlow = 1'b1;
            1: btn_lo = 1'b1;
            default: btn_ah = 1'b1;
        endcase
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == len) begin
                vlow = 1'b0; btn_lo = 1'b0; btn_ah = 1'b0;
            end
            a = (sel == 2) ? act_ah : act_lo;
            if (a) seen = 1'b1;
            else if (seen && n_fall == 0) n_fall = i;
            if (n_fall != 0 && i >= len) break;
        end
        vlow = 1'b0; btn_lo = 1'b0; btn_ah = 1'b0;
    endtask

    task automatic watch_quiet(input int cycles, input bit use_ah, output bit any);
        any = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (use_ah ? act_ah : act_lo) any = 1'b1;
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(act_lo == 1'b1, "R10", "status in reset", act_lo, 1);
        chk(drv_lo == 1'b1, "R9", "drive in reset", drv_lo, 1);
        chk(lvl_lo == 1'b0, "R9", "active-low level in reset", lvl_lo, 0);
        chk(lvl_ah == 1'b1, "R9", "active-high level in reset", lvl_ah, 1);
    endtask

    task automatic t_por_release();
        int n = 0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 1; i <= 4 * T; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (!act_lo) begin n = i; break; end
        end
        chk(n >= SF + T + 2 && n <= SF + T + 4, "R10", "por release edges", n, SF + T + 3);
        chk(lvl_lo == 1'b1 && drv_lo == 1'b0, "R9", "active-low level released", lvl_lo, 1);
        chk(lvl_ah == 1'b0 && act_ah == 1'b0, "R9", "active-high level released", lvl_ah, 0);
    endtask

    task automatic t_supply_dip();
        int n; bit seen;
        pulse_and_watch(0, 300, 800, n, seen);
        chk(seen, "R1", "long dip asserts", seen, 1);
        chk(n >= 300 + SF + T + 2 && n <= 300 + SF + T + 4, "R2", "release edges", n,
            300 + SF + T + 3);
    endtask

    task automatic t_supply_hold();
        bit held = 1'b1;
        @(negedge clk); vlow = 1'b1;
        repeat (SF + 4) @(negedge clk);
        chk(act_lo == 1'b1, "R1", "asserted within filter+4", act_lo, 1);
        for (int i = 0; i < 2 * T; i++) begin
            @(negedge clk);
            if (!act_lo) held = 1'b0;
        end
        chk(held, "R1", "held through dip", held, 1);
        vlow = 1'b0;
        repeat (SF + T + 10) @(negedge clk);
        chk(act_lo == 1'b0, "R2", "released after dip", act_lo, 0);
    endtask

    task automatic t_supply_glitch();
        int n; bit seen;
        pulse_and_watch(0, SF - 1, 2 * T, n, seen);
        chk(!seen, "R3", "short supply glitch ignored", seen, 0);
        pulse_and_watch(0, SF + 1, 4 * T, n, seen);
        chk(seen, "R3", "supply pulse over filter asserts", seen, 1);
        chk(n >= SF + 1 + SF + T + 2 && n <= SF + 1 + SF + T + 4, "R2",
            "release after short dip", n, SF + 1 + SF + T + 3);
    endtask

    task automatic t_manual_short();
        int n; bit seen;
        pulse_and_watch(1, MF - 1, 2 * T, n, seen);
        chk(!seen, "R4", "short manual pulse ignored", seen, 0);
    endtask

    task automatic t_manual_press();
        int n; bit seen; bit any;
        pulse_and_watch(1, MF + 1, 4 * T, n, seen);
        chk(seen, "R5", "press asserts", seen, 1);
        chk(n >= MF + T + 2 && n <= MF + T + 4, "R5", "stretched to timeout", n, MF + T + 3);
        watch_quiet(3 * T, 1'b0, any);
        chk(!any, "R7", "own drive not re-triggering", any, 0);
    endtask

    task automatic t_manual_held();
        int n; bit seen; bit any;
        pulse_and_watch(1, 3 * T, 6 * T, n, seen);
        chk(n >= MF + T + 2 && n <= MF + T + 4, "R6", "held press released on time", n,
            MF + T + 3);
        watch_quiet(2 * T, 1'b0, any);
        chk(!any, "R6", "button release no retrigger", any, 0);
    endtask

    task automatic t_restart();
        int n; bit seen;
        @(negedge clk); btn_ah = 1'b1;
        repeat (MF + 1) @(negedge clk);
        btn_ah = 1'b0;
        repeat (T / 2) @(negedge clk);
        chk(act_ah == 1'b1 && lvl_ah == 1'b1, "R9", "active-high level while active", lvl_ah, 1);
        pulse_and_watch(2, MF + 1, 4 * T, n, seen);
        chk(n >= MF + T + 2 && n <= MF + T + 4, "R8", "restart from second press", n,
            MF + T + 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary_and_end();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_por_release();
        t_supply_dip();
        t_supply_hold();
        t_supply_glitch();
        t_manual_short();
        t_manual_press();
        t_manual_held();
        t_restart();
        repeat (5) @(negedge clk);
        summary_and_end();
    end
endmodule